// File: doc/BRIEF.md
# USB Low/Full-Speed Bit-Level Receiver

This block recovers the bit stream of a USB low-speed or full-speed packet from raw samples of the two data lines. A speed-select input picks the symbol polarity and the nominal bit period. The block runs from a clock at four times the full-speed bit rate, which gives 4 clocks per full-speed bit and 32 clocks per low-speed bit. Each line passes through a two-stage synchronizer. The synchronized pair is then classified as one of four line symbols: J, K, single-ended zero (SE0) or single-ended one (SE1).

A J-to-K change on an idle line starts a packet. From that point a fractional phase accumulator places one sample point in the centre of each bit. Each sampled symbol is NRZI-decoded, and stuffed zeros are removed. An SE0 followed by J ends the packet. Each J/K edge seen while a packet is being received nudges the sample phase and the bit period by a small step, so the receiver follows a transmitter that runs slightly fast or slow.

Results appear as single-cycle pulses: packet start, data bit (valid plus value), stripped stuff bit, packet end and error. Byte assembly, PID and CRC handling belong to the layer above.

Top module: `usbrx_top`

## Requirements
- R1: Symbol mapping depends on the speed input. With `low_speed_i`=0, (dp,dm)=(1,0) is J and (0,1) is K. With `low_speed_i`=1, (0,1) is J and (1,0) is K. In both modes, (0,0) is SE0 and (1,1) is SE1.
- R2: Each line passes two synchronizer flops. While idle, a decoded symbol change from J to K gives one `sop_o` pulse and starts a packet. No other idle change does.
- R3: The first sample point falls half a nominal bit period after the K is first seen (2 clocks at full speed, 16 clocks at low speed). Further sample points follow one bit period apart (4 clocks at full speed, 32 at low speed).
- R4: A sampled J or K equal to the previously sampled symbol gives data 1. A different one gives data 0, and it is reported on `bit_o` with a `bit_vld_o` pulse. The symbol before the first sample counts as J.
- R5: After six consecutive data 1s, a sampled 0 is not output as data. Instead it gives a `stuff_o` pulse and clears the ones count.
- R6: After six consecutive data 1s, a sampled 1 gives an `err_o` pulse. The receiver then returns to idle and outputs nothing more until the next start of packet.
- R7: An SE0 sampled while bits are being received starts end-of-packet. Further SE0 samples keep waiting. A sampled J then gives one `eop_o` pulse and returns to idle.
- R8: While waiting for the end of a packet, a sampled K or SE1 gives an `err_o` pulse and returns to idle.
- R9: An SE1 sampled while bits are being received gives an `err_o` pulse and returns to idle.
- R10: A J/K edge seen later than mid-bit lengthens the period by 1/16 clock, up to +2/16, and retards the phase by 1/16 clock. An edge seen earlier than mid-bit does the opposite. A bit stream whose bits are occasionally one clock longer or shorter is still decoded correctly. The period returns to nominal whenever the receiver is idle.
- R11: All output pulses are low during and after reset, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 4x the full-speed bit rate |
| rst | input | 1 | Synchronous active-high reset |
| low_speed_i | input | 1 | 1 selects low-speed polarity and bit period |
| dp_i | input | 1 | Raw sample of the positive data line |
| dm_i | input | 1 | Raw sample of the negative data line |
| sop_o | output | 1 | Start-of-packet pulse |
| bit_vld_o | output | 1 | Data bit valid pulse |
| bit_o | output | 1 | Data bit value, qualified by bit_vld_o |
| stuff_o | output | 1 | Stripped stuff bit pulse |
| eop_o | output | 1 | End-of-packet pulse |
| err_o | output | 1 | Stuffing, line-state or end-of-packet error pulse |

## Verification
Packets with mixed data bytes at both speeds show that the polarity swap and both bit periods decode correctly. Runs of 1s longer than six are included, both with proper stuffing and with a missing stuff bit, to separate correct stripping from error detection. Packet endings with a long SE0, with K after SE0, with SE1 after SE0 and with SE1 among the data exercise each exit from the bit and end-of-packet phases. Streams where every 24th bit is one clock longer or shorter separate a tracking bit clock from a free-running one.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_SE1 = 2'b11
    } line_sym_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DATA = 2'b01,
        ST_EOP  = 2'b10
    } rx_state_e;

    typedef struct packed {
        logic sop;
        logic eop;
        logic stuff;
        logic err;
        logic bit_vld;
        logic bit_val;
    } rx_evt_t;

    // Classify a synchronized line pair; J and K swap with the speed mode.
    function automatic line_sym_e pair_to_sym(input logic dp, input logic dm,
                                              input logic low);
        line_sym_e s;
        case ({dp, dm})
            2'b00:   s = SYM_SE0;
            2'b11:   s = SYM_SE1;
            2'b10:   s = low ? SYM_K : SYM_J;
            default: s = low ? SYM_J : SYM_K;
        endcase
        return s;
    endfunction

    function automatic logic is_jk(input line_sym_e s);
        return (s == SYM_J) || (s == SYM_K);
    endfunction

endpackage

// File: rtl/usbrx_line_front.sv
module usbrx_line_front
    import usbrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      low_speed_i,
    input  logic      dp_i,
    input  logic      dm_i,
    output line_sym_e sym_o,
    output line_sym_e prev_o,
    output logic      edge_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] dp_sh, dm_sh;
    line_sym_e sym_q, prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    dp_sh[g] <= 1'b0;
                    dm_sh[g] <= 1'b0;
                end else if (g == 0) begin
                    dp_sh[g] <= dp_i;
                    dm_sh[g] <= dm_i;
                end else begin
                    dp_sh[g] <= dp_sh[(g == 0) ? 0 : g - 1];
                    dm_sh[g] <= dm_sh[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q  <= SYM_SE0;
            prev_q <= SYM_SE0;
        end else begin
            sym_q  <= pair_to_sym(dp_sh[MSB], dm_sh[MSB], low_speed_i);
            prev_q <= sym_q;
        end
    end

    assign sym_o  = sym_q;
    assign prev_o = prev_q;
    assign edge_o = is_jk(sym_q) && is_jk(prev_q) && (sym_q != prev_q);

endmodule

// File: rtl/usbrx_bit_clock.sv
module usbrx_bit_clock #(
    parameter int SPB_FS    = 4,
    parameter int SPB_LS    = 32,
    parameter int FRAC_BITS = 4,
    parameter int TRIM_MAX  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic low_speed_i,
    input  logic start_i,
    input  logic run_i,
    input  logic edge_i,
    output logic sample_o
);
    localparam int UNIT    = 1 << FRAC_BITS;
    localparam int PER_FS  = SPB_FS * UNIT;
    localparam int PER_LS  = SPB_LS * UNIT;
    localparam int PER_BIG = (PER_LS > PER_FS) ? PER_LS : PER_FS;
    localparam int AW      = $clog2(PER_BIG + UNIT + TRIM_MAX + 1) + 1;
    localparam int TW      = $clog2(TRIM_MAX + 1) + 1;
    localparam logic signed [TW-1:0] TRIM_HI   = TW'(TRIM_MAX);
    localparam logic signed [TW-1:0] TRIM_LO   = -TRIM_HI;
    localparam logic signed [TW-1:0] TRIM_STEP = 1;

    logic [AW-1:0] acc_q, acc_n, base, adj, per, per_nom, half;
    logic signed [TW-1:0] trim_q, trim_n;

    always_comb begin
        per_nom = low_speed_i ? AW'(PER_LS) : AW'(PER_FS);
        per     = per_nom + {{(AW-TW){trim_q[TW-1]}}, trim_q};
        half    = per >> 1;
        base    = acc_q + AW'(UNIT);
        adj     = base;
        trim_n  = trim_q;
        if (run_i && edge_i) begin
            if (base > half) begin
                adj = base - AW'(1);
                if (trim_q < TRIM_HI) trim_n = trim_q + TRIM_STEP;
            end else if (base < half) begin
                adj = base + AW'(1);
                if (trim_q > TRIM_LO) trim_n = trim_q - TRIM_STEP;
            end
        end
        sample_o = run_i && (adj >= per);
        acc_n    = sample_o ? (adj - per) : adj;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            trim_q <= '0;
        end else if (start_i) begin
            acc_q  <= low_speed_i ? AW'(PER_LS / 2) : AW'(PER_FS / 2);
            trim_q <= '0;
        end else if (run_i) begin
            acc_q  <= acc_n;
            trim_q <= trim_n;
        end else begin
            trim_q <= '0;
        end
    end

    // R10: the period correction never leaves its window
    p_trim_bounded_r10: assert property (@(posedge clk) disable iff (rst)
        (trim_q <= TRIM_HI) && (trim_q >= TRIM_LO));

    // R3: at full speed the first sample lands two clocks after start
    p_first_sample_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(start_i, 2) && !$past(edge_i) && !edge_i && run_i
         && !low_speed_i && !$past(low_speed_i, 2)) |-> sample_o);

endmodule

// File: rtl/usbrx_bit_engine.sv
module usbrx_bit_engine
    import usbrx_pkg::*;
#(
    parameter int MAX_ONES = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  line_sym_e sym_i,
    input  line_sym_e prev_i,
    input  logic      sample_i,
    output logic      start_o,
    output logic      run_o,
    output rx_evt_t   evt_o
);
    localparam int OW = $clog2(MAX_ONES + 1);
    localparam logic [OW-1:0] ONES_LIM = OW'(MAX_ONES);

    rx_state_e   state_q, state_n;
    line_sym_e   last_q, last_n;
    logic [OW-1:0] ones_q, ones_n;
    rx_evt_t     evt_q, evt_n;
    logic        nrzi;

    always_comb begin
        state_n = state_q;
        last_n  = last_q;
        ones_n  = ones_q;
        evt_n   = '0;
        start_o = 1'b0;
        nrzi    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (sym_i == SYM_K && prev_i == SYM_J) begin
                    start_o   = 1'b1;
                    evt_n.sop = 1'b1;
                    state_n   = ST_DATA;
                    last_n    = SYM_J;
                    ones_n    = '0;
                end
            end
            ST_DATA: begin
                if (sample_i) begin
                    if (sym_i == SYM_SE0) begin
                        state_n = ST_EOP;
                    end else if (sym_i == SYM_SE1) begin
                        evt_n.err = 1'b1;
                        state_n   = ST_IDLE;
                    end else begin
                        nrzi   = (sym_i == last_q);
                        last_n = sym_i;
                        if (ones_q == ONES_LIM) begin
                            if (!nrzi) begin
                                evt_n.stuff = 1'b1;
                                ones_n      = '0;
                            end else begin
                                evt_n.err = 1'b1;
                                state_n   = ST_IDLE;
                            end
                        end else begin
                            evt_n.bit_vld = 1'b1;
                            evt_n.bit_val = nrzi;
                            ones_n        = nrzi ? ones_q + OW'(1) : '0;
                        end
                    end
                end
            end
            ST_EOP: begin
                if (sample_i && sym_i != SYM_SE0) begin
                    if (sym_i == SYM_J) evt_n.eop = 1'b1;
                    else                evt_n.err = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            last_q  <= SYM_J;
            ones_q  <= '0;
            evt_q   <= '0;
        end else begin
            state_q <= state_n;
            last_q  <= last_n;
            ones_q  <= ones_n;
            evt_q   <= evt_n;
        end
    end

    assign run_o = (state_q != ST_IDLE);
    assign evt_o = evt_q;

    // R2: a start pulse only follows a J-to-K change
    p_sop_after_jk_r2: assert property (@(posedge clk) disable iff (rst)
        evt_q.sop |-> $past(sym_i == SYM_K && prev_i == SYM_J));

    // R7: an end pulse only follows a J sampled in the end-of-packet wait
    p_eop_from_wait_r7: assert property (@(posedge clk) disable iff (rst)
        evt_q.eop |-> $past(state_q == ST_EOP && sym_i == SYM_J && sample_i));

    // R5: the run-of-ones counter never passes the stuffing limit
    p_ones_capped_r5: assert property (@(posedge clk) disable iff (rst)
        ones_q <= ONES_LIM);

    // R11: never two result pulses in one cycle
    p_one_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_q.sop, evt_q.eop, evt_q.stuff, evt_q.err, evt_q.bit_vld}));

endmodule

// File: rtl/usbrx_top.sv
module usbrx_top
    import usbrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SPB_FS      = 4,
    parameter int SPB_LS      = 32,
    parameter int FRAC_BITS   = 4,
    parameter int TRIM_MAX    = 2,
    parameter int MAX_ONES    = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic low_speed_i,
    input  logic dp_i,
    input  logic dm_i,
    output logic sop_o,
    output logic bit_vld_o,
    output logic bit_o,
    output logic stuff_o,
    output logic eop_o,
    output logic err_o
);
    line_sym_e sym, prev;
    logic      jk_edge, sample, start, run;
    rx_evt_t   evt;

    usbrx_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst(rst), .low_speed_i(low_speed_i),
        .dp_i(dp_i), .dm_i(dm_i),
        .sym_o(sym), .prev_o(prev), .edge_o(jk_edge)
    );

    usbrx_bit_clock #(
        .SPB_FS(SPB_FS), .SPB_LS(SPB_LS),
        .FRAC_BITS(FRAC_BITS), .TRIM_MAX(TRIM_MAX)
    ) u_clock (
        .clk(clk), .rst(rst), .low_speed_i(low_speed_i),
        .start_i(start), .run_i(run), .edge_i(jk_edge),
        .sample_o(sample)
    );

    usbrx_bit_engine #(.MAX_ONES(MAX_ONES)) u_engine (
        .clk(clk), .rst(rst),
        .sym_i(sym), .prev_i(prev), .sample_i(sample),
        .start_o(start), .run_o(run), .evt_o(evt)
    );

    assign sop_o     = evt.sop;
    assign bit_vld_o = evt.bit_vld;
    assign bit_o     = evt.bit_val;
    assign stuff_o   = evt.stuff;
    assign eop_o     = evt.eop;
    assign err_o     = evt.err;

endmodule

// File: tb/usbrx_top_tb_top.sv
module usbrx_top_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, ls, dp, dm;
    logic sop_o, bit_vld_o, bit_o, stuff_o, eop_o, err_o;

    usbrx_top dut_i (
        .clk(clk), .rst(rst), .low_speed_i(ls), .dp_i(dp), .dm_i(dm),
        .sop_o(sop_o), .bit_vld_o(bit_vld_o), .bit_o(bit_o),
        .stuff_o(stuff_o), .eop_o(eop_o), .err_o(err_o)
    );

    // expected item codes: 0/1 data bit, 2 start, 3 end, 4 stuff, 5 error
    int    exp_q[$];
    string why_q[$];
    int    n_chk = 0, n_bad = 0;
    int    lvl, ones, bitcnt;
    int    stretch_every = 0, stretch_delta = 0;
    bit    done = 1'b0;

    task automatic check(input bit ok, input string r, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic expect_ev(input int code, input string r);
        exp_q.push_back(code);
        why_q.push_back(r);
    endtask

    function automatic int per_cyc();
        return ls ? 32 : 4;
    endfunction

    // symbols: 0 SE0, 1 J, 2 K, 3 SE1 (polarity per R1)
    task automatic drive(input int s, input int n);
        case (s)
            0: {dp, dm} = 2'b00;
            1: {dp, dm} = ls ? 2'b01 : 2'b10;
            2: {dp, dm} = ls ? 2'b10 : 2'b01;
            default: {dp, dm} = 2'b11;
        endcase
        repeat (n) @(negedge clk);
    endtask

    task automatic next_len(output int n);
        bitcnt++;
        n = per_cyc();
        if (stretch_every > 0 && (bitcnt % stretch_every) == 0) n = n + stretch_delta;
    endtask

    task automatic send_bit(input bit b, input string r);
        int n;
        if (ones == 6) begin
            expect_ev(4, "R5");
            lvl = 3 - lvl;
            next_len(n);
            drive(lvl, n);
            ones = 0;
        end
        expect_ev(b ? 1 : 0, r);
        if (!b) lvl = 3 - lvl;
        next_len(n);
        drive(lvl, n);
        ones = b ? ones + 1 : 0;
    endtask

    task automatic send_byte(input logic [7:0] v, input string r);
        for (int i = 0; i < 8; i++) send_bit(v[i], r);
    endtask

    task automatic start_pkt();
        ones = 0; bitcnt = 0; lvl = 1;
        expect_ev(2, "R2");
        send_byte(8'h80, "R4");
    endtask

    task automatic settle(input string r);
        drive(1, 8 * per_cyc());
        check(exp_q.size() == 0, r, exp_q.size(), 0);
    endtask

    task automatic finish_pkt(input int se0_bits, input string r);
        expect_ev(3, r);
        drive(0, se0_bits * per_cyc());
        drive(1, per_cyc());
        settle(r);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin : mon
        int n, code, want;
        string r;
        if (!rst) begin
            n = int'(sop_o) + int'(bit_vld_o) + int'(stuff_o) + int'(eop_o) + int'(err_o);
            if (n > 1) check(1'b0, "R11 one pulse", n, 1);
            if (n > 0) begin
                code = bit_vld_o ? int'(bit_o) : sop_o ? 2 : eop_o ? 3 : stuff_o ? 4 : 5;
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected output R6", code, -1);
                end else begin
                    want = exp_q.pop_front();
                    r    = why_q.pop_front();
                    check(code == want, r, code, want);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R11: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ls = 1'b0; dp = 1'b1; dm = 1'b0;
        repeat (5) @(negedge clk);
        check({sop_o, bit_vld_o, stuff_o, eop_o, err_o} == 5'b0, "R11 in reset",
              {sop_o, bit_vld_o, stuff_o, eop_o, err_o}, 0);
        rst = 1'b0;
        drive(1, 20);
        check({sop_o, bit_vld_o, stuff_o, eop_o, err_o} == 5'b0, "R11 after reset",
              {sop_o, bit_vld_o, stuff_o, eop_o, err_o}, 0);

        // R3/R4: full-speed packet with mixed data
        start_pkt();
        send_byte(8'hA5, "R3");
        send_byte(8'h3C, "R4");
        finish_pkt(2, "R7");

        // R5: long runs of ones with proper stuffing
        start_pkt();
        send_byte(8'hFF, "R5");
        send_byte(8'hFF, "R5");
        send_byte(8'h7E, "R5");
        finish_pkt(2, "R7");

        // R6: seventh 1 where a stuff bit is required
        start_pkt();
        for (int i = 0; i < 5; i++) send_bit(1'b1, "R6");
        expect_ev(5, "R6");
        drive(lvl, per_cyc());
        settle("R6");

        // R9: SE1 among the data
        start_pkt();
        send_byte(8'h55, "R9");
        expect_ev(5, "R9");
        drive(3, per_cyc());
        settle("R9");

        // R8: K after SE0, then SE1 after SE0
        start_pkt();
        send_byte(8'h12, "R8");
        expect_ev(5, "R8");
        drive(0, per_cyc());
        drive(2, per_cyc());
        settle("R8");
        start_pkt();
        send_byte(8'h34, "R8");
        expect_ev(5, "R8");
        drive(0, per_cyc());
        drive(3, per_cyc());
        settle("R8");

        // R7: three bit times of SE0 before J
        start_pkt();
        send_byte(8'h9B, "R7");
        finish_pkt(3, "R7");

        // R1: low-speed polarity and period
        drive(0, 8);
        ls = 1'b1;
        drive(0, 8);
        drive(1, 64);
        start_pkt();
        send_byte(8'hC3, "R1");
        send_byte(8'hFE, "R1");
        send_byte(8'h5A, "R1");
        finish_pkt(2, "R1");
        drive(0, 8);
        ls = 1'b0;
        drive(0, 8);
        drive(1, 16);

        // R10: slow transmitter, every 24th bit one clock longer
        stretch_every = 24; stretch_delta = 1;
        start_pkt();
        for (int k = 0; k < 8; k++) send_byte(8'h11 * k[7:0] + 8'h21, "R10");
        stretch_every = 0;
        finish_pkt(2, "R10");

        // R10: fast transmitter, every 24th bit one clock shorter
        stretch_every = 24; stretch_delta = -1;
        start_pkt();
        for (int k = 0; k < 8; k++) send_byte(8'h93 ^ (k[7:0] << 2), "R10");
        stretch_every = 0;
        finish_pkt(2, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule